// File: doc/BRIEF.md
# Horizontal Microprogrammed Control Unit

This block is a small execution engine driven by a horizontal control store. Each clock it reads one wide microword from a ROM. The fields of that word drive everything in the same cycle: two operand selects into a three-ported register file, a destination select, an ALU operation, a flag-update enable, a carry-in select and a memory transfer request. A jump type and a jump address in the same word choose the next micro-address. There is no separate decoder state machine. One jump type dispatches on the opcode held in the instruction register, so each machine instruction has its own short microroutine. All routines end with an unconditional microjump back to the fetch routine at micro-address 0.

Machine instructions are bytes: the opcode sits in bits [7:4], and an operand byte (if any) follows. Memory is modelled as a combinational read port. The memory address register drives it, and the bus value is captured into the memory data register or the instruction register at the clock edge. Register 7 of the file serves as the program counter.

Top module: `ucu_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the micro-address is 0, the flags are 0, the memory address is 0 and no register write is signalled. Every register file entry resets to 0, so the first fetch reads address 0. Reset is asynchronous and active-low, and its release passes through a two-stage synchroniser.
- R2: A microword with jump type NEXT sets the next micro-address to the current one plus 1.
- R3: A microword with jump type JMP loads its jump-address field as the next micro-address. Every instruction routine returns to micro-address 0 this way.
- R4: A dispatch microword jumps on the opcode in bits [7:4] of the instruction register. The targets are 0→8 (no-op), 1→10 (load immediate), 2→16 (add), 3→17 (add with carry), 4→18 (and), 5→19 (not), 6→20 (shift right), 7→21 (move r0 to r1), 8→24 (jump) and 9→26 (jump if zero). Opcodes 10 to 15 go to the no-op routine at 8.
- R5: A conditional microword jumps to its jump address when the stored Z flag is 1 and steps by one otherwise. Jump-if-zero therefore sets PC to its operand byte when Z=1 and otherwise steps PC past the operand.
- R6: The register file serves two reads and one write in each cycle. A read of the register being written in that cycle returns the old value, so add writes r0 ← r0 + r1 using the r0 value from before the edge.
- R7: The ALU results are as follows. Add gives a+b+cin, with C the carry out and V the signed overflow. And gives a&b. Not gives ~a. Shift right gives a>>1 with a zero filled in and C taking the bit shifted out. Pass gives a. For every operation except add and shift, C and V are 0. N is bit 7 of the result, and Z is 1 when the result is 0. flags_o is {N,Z,V,C} from bit 3 down to bit 0.
- R8: Flags change only when the microword's flag-update bit is set. The carry-in is either forced to 0 (add, PC increment) or taken from the stored C flag (add with carry).
- R9: An unused field is encoded as a no-op and leaves its unit idle. The NONE destination or the NOP ALU operation produces no register write and no flag change, so the no-op routine and move change no flags.
- R10: Fetch takes three microwords. The first copies PC into the memory address register. The second loads the opcode from memory into the instruction register and writes PC+1. The third copies the new PC into the memory address register and dispatches.
- R11: The jump instruction takes two microwords after dispatch. The first loads the operand byte into the memory data register and steps to the next microword. The second writes that byte into PC and jumps back to fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | DW | Memory address register value |
| mem_rdata | input | DW | Read data for mem_addr, same cycle |
| upc_o | output | CAW | Current micro-address |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |
| rf_we_o | output | 1 | Register file write strobe of this microword |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | DW | Register file write data |

## Verification
The assertions assume that mem_rdata is a pure function of mem_addr within the same cycle, and that the control store holds only jump types the sequencer decodes. The stimulus keeps to these assumptions: the bench answers reads from a fixed byte array indexed by the address output, and it never changes memory contents once the run has started. The program exercises each opcode at least once, takes the conditional jump both ways, drives the add result through carry and signed overflow, and ends in a self-loop, so the run stays inside mapped code.

// File: rtl/ucu_pkg.sv
package ucu_pkg;
  typedef enum logic [2:0] {
    ALU_NOP  = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_NOT  = 3'd3,
    ALU_SHR  = 3'd4,
    ALU_PASS = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    JT_NEXT = 2'd0,
    JT_JMP  = 2'd1,
    JT_DISP = 2'd2,
    JT_JZ   = 2'd3
  } jtype_e;

  typedef enum logic [1:0] {
    MEM_IDLE   = 2'd0,
    MEM_TO_MDR = 2'd1,
    MEM_TO_IR  = 2'd2
  } memop_e;

  // operand / destination select codes (codes below the file size address the file)
  localparam logic [3:0] REG_R0   = 4'd0;
  localparam logic [3:0] REG_R1   = 4'd1;
  localparam logic [3:0] REG_PC   = 4'd7;
  localparam logic [3:0] SEL_MAR  = 4'd8;
  localparam logic [3:0] SEL_MDR  = 4'd9;
  localparam logic [3:0] SEL_ONE  = 4'd10;
  localparam logic [3:0] SEL_ZERO = 4'd11;
  localparam logic [3:0] DST_MAR  = 4'd8;
  localparam logic [3:0] DST_IR   = 4'd9;
  localparam logic [3:0] DST_NONE = 4'd15;

  // flag bit positions
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;

  // microroutine entry points
  localparam int UA_FETCH = 0;
  localparam int UA_NOP   = 8;
  localparam int UA_LDI   = 10;
  localparam int UA_ADD   = 16;
  localparam int UA_ADC   = 17;
  localparam int UA_AND   = 18;
  localparam int UA_NOT   = 19;
  localparam int UA_SHR   = 20;
  localparam int UA_MOV   = 21;
  localparam int UA_JMP   = 24;
  localparam int UA_JZ    = 26;
endpackage

// File: rtl/ucu_alu.sv
module ucu_alu
  import ucu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic [3:0]      fl
);
  logic [DW:0] sum;
  logic        c_out;
  logic        v_out;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    res   = '0;
    c_out = 1'b0;
    v_out = 1'b0;
    case (op)
      ALU_ADD: begin
        res   = sum[DW-1:0];
        c_out = sum[DW];
        v_out = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
      end
      ALU_AND:  res = a & b;
      ALU_NOT:  res = ~a;
      ALU_SHR: begin
        res   = {1'b0, a[DW-1:1]};
        c_out = a[0];
      end
      ALU_PASS: res = a;
      default:  res = '0;
    endcase
    fl       = '0;
    fl[FL_N] = res[DW-1];
    fl[FL_Z] = (res == '0);
    fl[FL_V] = v_out;
    fl[FL_C] = c_out;
  end
endmodule

// File: rtl/ucu_rf.sv
module ucu_rf #(
  parameter int DW   = 8,
  parameter int RF_N = 8,
  localparam int RIW = $clog2(RF_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIW-1:0]  ra_a,
  input  logic [RIW-1:0]  ra_b,
  output logic [DW-1:0]   rd_a,
  output logic [DW-1:0]   rd_b,
  input  logic            we,
  input  logic [RIW-1:0]  wa,
  input  logic [DW-1:0]   wd
);
  logic [DW-1:0] regs_q [RF_N];

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_N; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[wa] <= wd;
    end
  end
endmodule

// File: rtl/ucu_seq.sv
module ucu_seq
  import ucu_pkg::*;
#(
  parameter int CAW = 6,
  parameter int OPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  jtype_e          jt,
  input  logic [CAW-1:0]  ja,
  input  logic            zflag,
  input  logic [OPW-1:0]  opcode,
  output logic [CAW-1:0]  upc
);
  logic [CAW-1:0] upc_d;
  logic [CAW-1:0] disp_addr;

  always_comb begin
    case (opcode)
      4'd1:    disp_addr = CAW'(UA_LDI);
      4'd2:    disp_addr = CAW'(UA_ADD);
      4'd3:    disp_addr = CAW'(UA_ADC);
      4'd4:    disp_addr = CAW'(UA_AND);
      4'd5:    disp_addr = CAW'(UA_NOT);
      4'd6:    disp_addr = CAW'(UA_SHR);
      4'd7:    disp_addr = CAW'(UA_MOV);
      4'd8:    disp_addr = CAW'(UA_JMP);
      4'd9:    disp_addr = CAW'(UA_JZ);
      default: disp_addr = CAW'(UA_NOP);
    endcase
  end

  always_comb begin
    case (jt)
      JT_JMP:  upc_d = ja;
      JT_DISP: upc_d = disp_addr;
      JT_JZ:   upc_d = zflag ? ja : upc + 1'b1;
      default: upc_d = upc + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= CAW'(UA_FETCH);
    else        upc <= upc_d;
  end
endmodule

// File: rtl/ucu_cstore.sv
module ucu_cstore
  import ucu_pkg::*;
#(
  parameter int CAW   = 6,
  parameter int DEPTH = 64,
  parameter int UW_W  = 32
) (
  input  logic [CAW-1:0]  addr,
  output logic [3:0]      sa,
  output logic [3:0]      sb,
  output logic [3:0]      dst,
  output alu_op_e         alu,
  output jtype_e          jt,
  output logic [CAW-1:0]  ja,
  output logic            fupd,
  output logic            cin_sel,
  output memop_e          mop
);
  // word layout, MSB down: srcA | srcB | dst | alu | jump type | jump addr | fupd | cin | mem
  localparam int P_MEM  = 0;
  localparam int P_CIN  = 2;
  localparam int P_FUPD = 3;
  localparam int P_JA   = 4;
  localparam int P_JT   = P_JA + CAW;
  localparam int P_ALU  = P_JT + 2;
  localparam int P_DST  = P_ALU + 3;
  localparam int P_SB   = P_DST + 4;
  localparam int P_SA   = P_SB + 4;
  localparam int USED   = P_SA + 4;

  function automatic logic [UW_W-1:0] mk(input logic [3:0] a_s, input logic [3:0] b_s,
                                         input logic [3:0] d_s, input alu_op_e op,
                                         input jtype_e j, input int jaddr,
                                         input logic f, input logic c, input memop_e m);
    logic [UW_W-1:0] w;
    w = '0;
    w[P_SA +: 4]   = a_s;
    w[P_SB +: 4]   = b_s;
    w[P_DST +: 4]  = d_s;
    w[P_ALU +: 3]  = op;
    w[P_JT +: 2]   = j;
    w[P_JA +: CAW] = CAW'(jaddr);
    w[P_FUPD]      = f;
    w[P_CIN]       = c;
    w[P_MEM +: 2]  = m;
    return w;
  endfunction

  function automatic logic [UW_W-1:0] rom_word(input int a);
    case (a)
      0:  return mk(REG_PC,   SEL_ZERO, DST_MAR,  ALU_PASS, JT_NEXT, 0, 1'b0, 1'b0, MEM_IDLE);
      1:  return mk(REG_PC,   SEL_ONE,  REG_PC,   ALU_ADD,  JT_NEXT, 0, 1'b0, 1'b0, MEM_TO_IR);
      2:  return mk(REG_PC,   SEL_ZERO, DST_MAR,  ALU_PASS, JT_DISP, 0, 1'b0, 1'b0, MEM_IDLE);
      10: return mk(REG_PC,   SEL_ONE,  REG_PC,   ALU_ADD,  JT_NEXT, 0, 1'b0, 1'b0, MEM_TO_MDR);
      11: return mk(SEL_MDR,  SEL_ZERO, REG_R0,   ALU_PASS, JT_JMP,  0, 1'b1, 1'b0, MEM_IDLE);
      16: return mk(REG_R0,   REG_R1,   REG_R0,   ALU_ADD,  JT_JMP,  0, 1'b1, 1'b0, MEM_IDLE);
      17: return mk(REG_R0,   REG_R1,   REG_R0,   ALU_ADD,  JT_JMP,  0, 1'b1, 1'b1, MEM_IDLE);
      18: return mk(REG_R0,   REG_R1,   REG_R0,   ALU_AND,  JT_JMP,  0, 1'b1, 1'b0, MEM_IDLE);
      19: return mk(REG_R0,   SEL_ZERO, REG_R0,   ALU_NOT,  JT_JMP,  0, 1'b1, 1'b0, MEM_IDLE);
      20: return mk(REG_R0,   SEL_ZERO, REG_R0,   ALU_SHR,  JT_JMP,  0, 1'b1, 1'b0, MEM_IDLE);
      21: return mk(REG_R0,   SEL_ZERO, REG_R1,   ALU_PASS, JT_JMP,  0, 1'b0, 1'b0, MEM_IDLE);
      24: return mk(SEL_ZERO, SEL_ZERO, DST_NONE, ALU_NOP,  JT_NEXT, 0, 1'b0, 1'b0, MEM_TO_MDR);
      25: return mk(SEL_MDR,  SEL_ZERO, REG_PC,   ALU_PASS, JT_JMP,  0, 1'b0, 1'b0, MEM_IDLE);
      26: return mk(SEL_ZERO, SEL_ZERO, DST_NONE, ALU_NOP,  JT_JZ,   UA_JMP, 1'b0, 1'b0, MEM_IDLE);
      27: return mk(REG_PC,   SEL_ONE,  REG_PC,   ALU_ADD,  JT_JMP,  0, 1'b0, 1'b0, MEM_IDLE);
      default: return mk(SEL_ZERO, SEL_ZERO, DST_NONE, ALU_NOP, JT_JMP, UA_FETCH, 1'b0, 1'b0, MEM_IDLE);
    endcase
  endfunction

  logic [UW_W-1:0] rom [DEPTH];
  logic [UW_W-1:0] word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = rom_word(i);
  end

  assign word    = rom[addr];
  assign sa      = word[P_SA +: 4];
  assign sb      = word[P_SB +: 4];
  assign dst     = word[P_DST +: 4];
  assign alu     = alu_op_e'(word[P_ALU +: 3]);
  assign jt      = jtype_e'(word[P_JT +: 2]);
  assign ja      = word[P_JA +: CAW];
  assign fupd    = word[P_FUPD];
  assign cin_sel = word[P_CIN];
  assign mop     = memop_e'(word[P_MEM +: 2]);

  if (UW_W > USED) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^word[UW_W-1:USED];
  end
endmodule

// File: rtl/ucu_top.sv
module ucu_top
  import ucu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CS_DEPTH = 64,
  parameter int UW_W     = 32,
  parameter int RF_N     = 8,
  localparam int CAW     = $clog2(CS_DEPTH),
  localparam int RIW     = $clog2(RF_N),
  localparam int OPW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [DW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [CAW-1:0]  upc_o,
  output logic [3:0]      flags_o,
  output logic            rf_we_o,
  output logic [RIW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  logic [CAW-1:0] upc;
  logic [3:0]     sa, sb, dst;
  alu_op_e        alu;
  jtype_e         jt;
  logic [CAW-1:0] ja;
  logic           fupd, cin_sel;
  memop_e         mop;

  logic [DW-1:0]  rf_a, rf_b, op_a, op_b, alu_res;
  logic [3:0]     alu_fl;
  logic [3:0]     flags_q, flags_d;
  logic [DW-1:0]  mar_q, mar_d, mdr_q, mdr_d;
  logic [OPW-1:0] ir_q, ir_d;
  logic           mar_en, mdr_en, ir_en, fl_en, rf_we;

  ucu_cstore #(.CAW(CAW), .DEPTH(CS_DEPTH), .UW_W(UW_W)) u_cstore (
    .addr(upc), .sa(sa), .sb(sb), .dst(dst), .alu(alu), .jt(jt), .ja(ja),
    .fupd(fupd), .cin_sel(cin_sel), .mop(mop)
  );

  ucu_seq #(.CAW(CAW), .OPW(OPW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .jt(jt), .ja(ja), .zflag(flags_q[FL_Z]),
    .opcode(ir_q), .upc(upc)
  );

  ucu_rf #(.DW(DW), .RF_N(RF_N)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .ra_a(sa[RIW-1:0]), .ra_b(sb[RIW-1:0]),
    .rd_a(rf_a), .rd_b(rf_b), .we(rf_we), .wa(dst[RIW-1:0]), .wd(alu_res)
  );

  function automatic logic [DW-1:0] pick(input logic [3:0] s, input logic [DW-1:0] rfv,
                                         input logic [DW-1:0] mar, input logic [DW-1:0] mdr);
    if (32'(s) < RF_N) return rfv;
    case (s)
      SEL_MAR: return mar;
      SEL_MDR: return mdr;
      SEL_ONE: return DW'(1);
      default: return '0;
    endcase
  endfunction

  assign op_a = pick(sa, rf_a, mar_q, mdr_q);
  assign op_b = pick(sb, rf_b, mar_q, mdr_q);

  ucu_alu #(.DW(DW)) u_alu (
    .op(alu), .a(op_a), .b(op_b), .cin(cin_sel & flags_q[FL_C]),
    .res(alu_res), .fl(alu_fl)
  );

  // next-state and enables
  always_comb begin
    rf_we   = rst_sync_n && (alu != ALU_NOP) && (32'(dst) < RF_N);
    mar_en  = (alu != ALU_NOP) && (dst == DST_MAR);
    mar_d   = alu_res;
    mdr_en  = (mop == MEM_TO_MDR);
    mdr_d   = mem_rdata;
    ir_en   = (mop == MEM_TO_IR) || ((alu != ALU_NOP) && (dst == DST_IR));
    ir_d    = (mop == MEM_TO_IR) ? mem_rdata[DW-1 -: OPW] : alu_res[DW-1 -: OPW];
    fl_en   = fupd && (alu != ALU_NOP);
    flags_d = alu_fl;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      flags_q <= '0;
    end else begin
      if (mar_en) mar_q   <= mar_d;
      if (mdr_en) mdr_q   <= mdr_d;
      if (ir_en)  ir_q    <= ir_d;
      if (fl_en)  flags_q <= flags_d;
    end
  end

  assign mem_addr   = mar_q;
  assign upc_o      = upc;
  assign flags_o    = flags_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = dst[RIW-1:0];
  assign rf_wdata_o = alu_res;
endmodule

// File: rtl/ucu_chk.sv
module ucu_chk
  import ucu_pkg::*;
#(
  parameter int CAW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CAW-1:0] upc,
  input jtype_e         jt,
  input logic [CAW-1:0] ja,
  input logic [3:0]     dst,
  input alu_op_e        alu,
  input logic           fupd,
  input logic           rf_we,
  input logic [3:0]     flags
);
  a_r2_next_step: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == JT_NEXT) |=> (upc == CAW'($past(upc) + 1'b1)));

  a_r3_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == JT_JMP) |=> (upc == $past(ja)));

  a_r4_dispatch_into_routines: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == JT_DISP) |=> (32'(upc) >= UA_NOP));

  a_r5_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == JT_JZ && flags[FL_Z]) |=> (upc == $past(ja)));

  a_r5_jz_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == JT_JZ && !flags[FL_Z]) |=> (upc == CAW'($past(upc) + 1'b1)));

  a_r9_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == DST_NONE || alu == ALU_NOP) |-> !rf_we);

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fupd && alu != ALU_NOP) |=> $stable(flags));
endmodule

bind ucu_top ucu_chk #(.CAW(CAW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .upc(upc), .jt(jt), .ja(ja), .dst(dst),
  .alu(alu), .fupd(fupd), .rf_we(rf_we), .flags(flags_q)
);

// File: tb/ucu_top_tb.sv
`timescale 1ns/1ps
module ucu_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mem_addr, mem_rdata;
  logic [5:0] upc_o;
  logic [3:0] flags_o;
  logic       rf_we_o;
  logic [2:0] rf_waddr_o;
  logic [7:0] rf_wdata_o;

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr];

  always #2.5 clk = ~clk;

  ucu_top u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .upc_o(upc_o), .flags_o(flags_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected per-cycle records
  int    q_upc[$], q_mar[$], q_fl[$], q_we[$], q_wa[$], q_wd[$];
  string q_tag[$];

  // behavioural model state
  int r[8];
  int mar, fl, mdr, ir;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int u, input int we, input int wa, input int wd, input string tag);
    q_upc.push_back(u);  q_mar.push_back(mar); q_fl.push_back(fl);
    q_we.push_back(we);  q_wa.push_back(wa);   q_wd.push_back(wd);
    q_tag.push_back(tag);
  endtask

  task automatic alu(input int op, input int a, input int b, input int cin,
                     output int res, output int f);
    int c, v, s;
    c = 0; v = 0;
    case (op)
      1: begin s = a + b + cin; res = s & 255; c = (s >> 8) & 1;
               v = (((a ^ res) & (b ^ res) & 128) != 0) ? 1 : 0; end
      2: res = a & b;
      3: res = (~a) & 255;
      4: begin res = a >> 1; c = a & 1; end
      default: res = a;
    endcase
    f = (((res >> 7) & 1) << 3) | ((res == 0 ? 1 : 0) << 2) | (v << 1) | c;
  endtask

  task automatic exec_one();
    int res, f;
    push(0, 0, 0, 0, "R3/R10");                    mar = r[7];
    push(1, 1, 7, (r[7] + 1) & 255, "R2/R10");     ir = int'(mem[mar]) >> 4; r[7] = (r[7] + 1) & 255;
    push(2, 0, 0, 0, "R2/R10");                    mar = r[7];
    case (ir)
      1: begin
        push(10, 1, 7, (r[7] + 1) & 255, "R4/R2"); mdr = int'(mem[mar]); r[7] = (r[7] + 1) & 255;
        alu(5, mdr, 0, 0, res, f);
        push(11, 1, 0, res, "R7/R8");              r[0] = res; fl = f;
      end
      2: begin alu(1, r[0], r[1], 0, res, f);      push(16, 1, 0, res, "R4/R6/R7"); r[0] = res; fl = f; end
      3: begin alu(1, r[0], r[1], fl & 1, res, f); push(17, 1, 0, res, "R4/R8");    r[0] = res; fl = f; end
      4: begin alu(2, r[0], r[1], 0, res, f);      push(18, 1, 0, res, "R4/R7");    r[0] = res; fl = f; end
      5: begin alu(3, r[0], 0, 0, res, f);         push(19, 1, 0, res, "R4/R7");    r[0] = res; fl = f; end
      6: begin alu(4, r[0], 0, 0, res, f);         push(20, 1, 0, res, "R4/R7");    r[0] = res; fl = f; end
      7: begin push(21, 1, 1, r[0], "R4/R9"); r[1] = r[0]; end
      8: begin
        push(24, 0, 0, 0, "R4/R11"); mdr = int'(mem[mar]);
        push(25, 1, 7, mdr, "R11");  r[7] = mdr;
      end
      9: begin
        push(26, 0, 0, 0, "R4/R5");
        if ((fl & 4) != 0) begin
          push(24, 0, 0, 0, "R5");     mdr = int'(mem[mar]);
          push(25, 1, 7, mdr, "R5/R11"); r[7] = mdr;
        end else begin
          push(27, 1, 7, (r[7] + 1) & 255, "R5"); r[7] = (r[7] + 1) & 255;
        end
      end
      default: push(8, 0, 0, 0, "R4/R9");
    endcase
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // program: opcode in [7:4]
    mem[0]  = 8'h10; mem[1]  = 8'h7F;   // LDI 7F
    mem[2]  = 8'h70;                    // MOV r1=r0
    mem[3]  = 8'h20;                    // ADD -> FE, overflow
    mem[4]  = 8'h10; mem[5]  = 8'hFF;   // LDI FF
    mem[6]  = 8'h20;                    // ADD -> 7E, carry
    mem[7]  = 8'h30;                    // ADC with C=1
    mem[8]  = 8'h50;                    // NOT
    mem[9]  = 8'h60;                    // SHR -> 0, C=1
    mem[10] = 8'h30;                    // ADC 0+7F+1
    mem[11] = 8'h10; mem[12] = 8'h00;   // LDI 0 -> Z
    mem[13] = 8'h90; mem[14] = 8'h12;   // JZ taken -> 0x12
    mem[15] = 8'hA0;                    // skipped
    mem[18] = 8'h40;                    // AND
    mem[19] = 8'h50;                    // NOT -> FF
    mem[20] = 8'h90; mem[21] = 8'h30;   // JZ not taken
    mem[22] = 8'hA5;                    // unmapped opcode -> no-op routine
    mem[23] = 8'h00;                    // NOP
    mem[24] = 8'h80; mem[25] = 8'h18;   // JMP self

    for (int i = 0; i < 8; i++) r[i] = 0;
    mar = 0; fl = 0; mdr = 0; ir = 0;
    while (q_upc.size() < 460) exec_one();

    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held
    check(upc_o == 6'd0,  "R1", "upc in reset",   int'(upc_o), 0);
    check(flags_o == 4'd0, "R1", "flags in reset", int'(flags_o), 0);
    check(mem_addr == 8'd0, "R1", "mar in reset", int'(mem_addr), 0);
    check(rf_we_o == 1'b0, "R1", "write in reset", int'(rf_we_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(upc_o == 6'd0 && rf_we_o == 1'b0, "R1", "upc held during sync release", int'(upc_o), 0);
    @(posedge clk);

    for (int k = 0; k < 450; k++) begin
      @(negedge clk);
      check(int'(upc_o) == q_upc[k], q_tag[k], "upc", int'(upc_o), q_upc[k]);
      check(int'(mem_addr) == q_mar[k], q_tag[k], "mem_addr", int'(mem_addr), q_mar[k]);
      check(int'(flags_o) == q_fl[k], q_tag[k], "flags", int'(flags_o), q_fl[k]);
      check(int'(rf_we_o) == q_we[k], q_tag[k], "rf_we", int'(rf_we_o), q_we[k]);
      if (q_we[k] != 0) begin
        check(int'(rf_waddr_o) == q_wa[k], q_tag[k], "rf_waddr", int'(rf_waddr_o), q_wa[k]);
        check(int'(rf_wdata_o) == q_wd[k], q_tag[k], "rf_wdata", int'(rf_wdata_o), q_wd[k]);
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule